// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Target Buffer

This block sits beside the fetch stage of an in-order pipeline and guesses, in the same cycle as the fetch, where the next instruction comes from. It has two parts. The first is a table of 2-bit saturating counters, picked by low bits of the fetch address, that gives the taken or not-taken guess. The second is a direct-mapped cache of branch targets, tagged with the upper address bits. When the cache holds the fetched address and the counter says taken, the block offers the cached target as the next fetch address, so a correctly predicted taken branch costs no bubble. Otherwise the next address it offers is the sequential one.

When a branch resolves further down the pipe, the pipeline reports it on the training inputs: the branch address, whether it went, where it went and whether the guess was wrong. Each report moves the branch's counter one step toward the real outcome. Because of this hysteresis, a loop-closing branch is mispredicted once per loop exit rather than twice. A taken report also writes or refreshes the target entry. A wrong guess is passed on as a flush request. The flushing itself and the fetch multiplexer are left to the surrounding pipeline.

Top module: `branch_guess_unit`

## Requirements
- R1: After reset every counter holds 01 (weak not-taken) and every target entry is invalid, so every lookup reports no hit, not-taken, and a next address of fetch_pc + 4.
- R2: Each resolved branch moves the counter at index upd_pc[7:2] up by one if taken and down by one if not taken, saturating at 00 and 11. The guess is taken when the counter's upper bit is 1 (states 10 and 11).
- R3: A counter at 11 still predicts taken after one not-taken report and predicts not-taken only after a second one. The same holds for a counter at 00 and taken reports.
- R4: Counters are indexed by pc[7:2] only. Addresses that differ only above bit 7 share a counter, and addresses that differ in bits 7:2 train independently.
- R5: A taken report writes the target entry at index upd_pc[5:2] with valid = 1, tag = upd_pc[31:6] and the reported target. A lookup hits when the entry at fetch_pc[5:2] is valid and its tag equals fetch_pc[31:6].
- R6: A not-taken report leaves the target buffer unchanged. An existing entry still hits with its old target.
- R7: An address with the same buffer index but a different tag misses. A taken report for it replaces the entry, after which the earlier address misses.
- R8: pred_next_pc equals the cached target when the lookup hits and the counter predicts taken (pred_redirect = 1). Otherwise it is fetch_pc + 4, including a hit whose counter predicts not-taken.
- R9: A lookup in the same cycle as a report to the same entries returns the contents from before the report. The new contents are visible from the next cycle.
- R10: flush_req is 1 in exactly the cycles where upd_valid and upd_mispredict are both 1. The mispredict flag has no effect on how counters or target entries are trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Target buffer holds fetch_pc |
| pred_taken | output | 1 | Counter for fetch_pc predicts taken |
| pred_redirect | output | 1 | Hit and predicted taken: fetch should jump |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |
| upd_mispredict | input | 1 | The earlier guess for this branch was wrong |
| flush_req | output | 1 | Request to flush younger instructions |

## Verification
The assertions assume that upd_valid and the other report inputs come from a clean register stage, so they are known after reset and stay steady across each rising edge. They also assume that at most one branch resolves per cycle. The bench changes all inputs one time unit after the rising edge and applies at most one report per cycle, so it stays inside these assumptions. Branch addresses are word aligned, and the checks make no claim about what the two low address bits do. The directed sequences cover saturation, aliasing and replacement, and a pseudo-random sweep draws addresses from a small window that reuses indices often.

// File: rtl/bgu_pkg.sv
package bgu_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    localparam ctr_t CTR_RESET = CTR_WEAK_NT;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic went);
        ctr_t nxt;
        case (cur)
            CTR_STRONG_NT: nxt = went ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = went ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = went ? CTR_STRONG_T : CTR_WEAK_NT;
            default:       nxt = went ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bgu_counter_table.sv
module bgu_counter_table
    import bgu_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    typedef struct packed {
        ctr_t [ENTRIES-1:0] ctr;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.ctr[wr_idx] = ctr_step(state_q.ctr[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_q.ctr[i] <= CTR_RESET;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_taken = state_q.ctr[rd_idx][1];

    // R2: saturation at the top
    p_sat_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && state_q.ctr[wr_idx] == CTR_STRONG_T)
        |=> state_q.ctr[$past(wr_idx)] == CTR_STRONG_T);

    // R2: saturation at the bottom
    p_sat_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && state_q.ctr[wr_idx] == CTR_STRONG_NT)
        |=> state_q.ctr[$past(wr_idx)] == CTR_STRONG_NT);

    // R2: counters move only on a report
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q));

endmodule

// File: rtl/bgu_target_buffer.sv
module bgu_target_buffer #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - 2 - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } btb_state_t;

    btb_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.slot[wr_idx].valid  = 1'b1;
            state_d.slot[wr_idx].tag    = wr_tag;
            state_d.slot[wr_idx].target = wr_target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_q.slot[i] <= '0;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_hit    = state_q.slot[rd_idx].valid && (state_q.slot[rd_idx].tag == rd_tag);
    assign rd_target = state_q.slot[rd_idx].target;

    // R5: a write leaves a valid entry holding the written tag and target
    p_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q.slot[$past(wr_idx)].valid
                   && state_q.slot[$past(wr_idx)].tag == $past(wr_tag)
                   && state_q.slot[$past(wr_idx)].target == $past(wr_target)));

    // R6: without a write the buffer keeps its contents
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q));

endmodule

// File: rtl/branch_guess_unit.sv
module branch_guess_unit #(
    parameter int PC_W        = 32,
    parameter int CNT_ENTRIES = 64,
    parameter int BTB_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic            pred_redirect,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_mispredict,
    output logic            flush_req
);

    localparam int CNT_IDX_W = $clog2(CNT_ENTRIES);
    localparam int BTB_IDX_W = $clog2(BTB_ENTRIES);
    localparam int TAG_W     = PC_W - 2 - BTB_IDX_W;
    localparam int CNT_HI    = CNT_IDX_W + 1;
    localparam int BTB_HI    = BTB_IDX_W + 1;

    logic            cnt_taken;
    logic            btb_hit;
    logic [PC_W-1:0] btb_target;
    logic [1:0]      upd_low_unused;

    assign upd_low_unused = upd_pc[1:0];

    bgu_counter_table #(
        .ENTRIES (CNT_ENTRIES)
    ) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[CNT_HI:2]),
        .rd_taken (cnt_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[CNT_HI:2]),
        .wr_taken (upd_taken)
    );

    bgu_target_buffer #(
        .PC_W    (PC_W),
        .ENTRIES (BTB_ENTRIES)
    ) u_targets (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_pc[BTB_HI:2]),
        .rd_tag    (fetch_pc[PC_W-1:BTB_HI+1]),
        .rd_hit    (btb_hit),
        .rd_target (btb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_idx    (upd_pc[BTB_HI:2]),
        .wr_tag    (upd_pc[PC_W-1:BTB_HI+1]),
        .wr_target (upd_target)
    );

    assign pred_hit      = btb_hit;
    assign pred_taken    = cnt_taken;
    assign pred_redirect = btb_hit && cnt_taken;
    assign pred_next_pc  = pred_redirect ? btb_target : fetch_pc + PC_W'(4);
    assign flush_req     = upd_valid && upd_mispredict;

    // R8: a redirect always points at a cached target, never the sequential address
    p_redirect_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pred_redirect |-> (pred_next_pc == btb_target));

    initial begin
        a_tag_width_r5: assert (TAG_W > 0);
    end

endmodule

// File: tb/branch_guess_unit_bench.sv
module branch_guess_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_pc;
    logic        pred_hit, pred_taken, pred_redirect;
    logic [31:0] pred_next_pc;
    logic        upd_valid, upd_taken, upd_mispredict;
    logic [31:0] upd_pc, upd_target;
    logic        flush_req;

    always #4 clk = ~clk;

    branch_guess_unit u_branch_guess_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .pred_hit       (pred_hit),
        .pred_taken     (pred_taken),
        .pred_redirect  (pred_redirect),
        .pred_next_pc   (pred_next_pc),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_target     (upd_target),
        .upd_mispredict (upd_mispredict),
        .flush_req      (flush_req)
    );

    int checks = 0;
    int failures = 0;

    // bench-side model of the requirements
    logic [1:0]  m_cnt [64];
    bit          m_val [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];

    typedef struct {
        logic        hit;
        logic        taken;
        logic        redirect;
        logic [31:0] nxt;
        logic        flush;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    // pending report, applied to the model after its clock edge
    bit          pend_v;
    logic [31:0] pend_pc, pend_tgt;
    logic        pend_t;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic model_apply();
        int ci, bi;
        if (!pend_v) return;
        ci = int'(pend_pc[7:2]);
        if (pend_t) begin
            if (m_cnt[ci] != 2'b11) m_cnt[ci] = m_cnt[ci] + 2'd1;
            bi = int'(pend_pc[5:2]);
            m_val[bi] = 1'b1;
            m_tag[bi] = pend_pc[31:6];
            m_tgt[bi] = pend_tgt;
        end else begin
            if (m_cnt[ci] != 2'b00) m_cnt[ci] = m_cnt[ci] - 2'd1;
        end
        pend_v = 1'b0;
    endtask

    // driver: one cycle of stimulus, expected values pushed to the scoreboard
    task automatic step(input logic [31:0] fpc, input bit uv, input logic [31:0] upc,
                        input bit ut, input logic [31:0] utgt, input bit um,
                        input string req);
        exp_t e;
        int ci, bi;
        @(posedge clk);
        #1;
        model_apply();
        fetch_pc       = fpc;
        upd_valid      = uv;
        upd_pc         = upc;
        upd_taken      = ut;
        upd_target     = utgt;
        upd_mispredict = um;
        ci = int'(fpc[7:2]);
        bi = int'(fpc[5:2]);
        e.hit      = m_val[bi] && (m_tag[bi] == fpc[31:6]);
        e.taken    = m_cnt[ci][1];
        e.redirect = e.hit && e.taken;
        e.nxt      = e.redirect ? m_tgt[bi] : fpc + 32'd4;
        e.flush    = uv && um;
        e.req      = req;
        sb_q.push_back(e);
        pend_v   = uv;
        pend_pc  = upc;
        pend_t   = ut;
        pend_tgt = utgt;
    endtask

    task automatic look(input logic [31:0] fpc, input string req);
        step(fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, req);
    endtask

    task automatic train(input logic [31:0] pc, input bit t, input logic [31:0] tgt,
                         input bit mis, input string req);
        step(pc, 1'b1, pc, t, tgt, mis, req);
    endtask

    // monitor: compares outputs in the middle of each cycle
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(pred_hit == e.hit, e.req, "pred_hit", 32'(pred_hit), 32'(e.hit));
            check(pred_taken == e.taken, e.req, "pred_taken", 32'(pred_taken), 32'(e.taken));
            check(pred_redirect == e.redirect, e.req, "pred_redirect",
                  32'(pred_redirect), 32'(e.redirect));
            check(pred_next_pc == e.nxt, e.req, "pred_next_pc", pred_next_pc, e.nxt);
            check(flush_req == e.flush, e.req, "flush_req", 32'(flush_req), 32'(e.flush));
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 64; i++) m_cnt[i] = 2'b01;
        for (int i = 0; i < 16; i++) begin
            m_val[i] = 1'b0;
            m_tag[i] = '0;
            m_tgt[i] = '0;
        end
        pend_v = 1'b0;
        rst_n = 1'b0;
        fetch_pc = 32'h0; upd_valid = 1'b0; upd_pc = 32'h0;
        upd_taken = 1'b0; upd_target = 32'h0; upd_mispredict = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: cold state
        look(32'h0000_0100, "R1");
        look(32'h0000_01FC, "R1");
        look(32'hFFFF_FFF0, "R1");

        // R9: lookup in the report cycle sees old contents; R5: then hits
        train(32'h0000_0100, 1'b1, 32'h0000_0400, 1'b1, "R9");
        look(32'h0000_0100, "R5");
        train(32'h0000_0100, 1'b1, 32'h0000_0400, 1'b0, "R2");
        look(32'h0000_0100, "R8");

        // R3: one not-taken from 11 keeps taken, a second flips it
        train(32'h0000_0100, 1'b0, 32'h0000_0000, 1'b1, "R10");
        look(32'h0000_0100, "R3");
        train(32'h0000_0100, 1'b0, 32'h0000_0000, 1'b0, "R10");
        // R6 and R8: hit is kept but counter says not-taken, so sequential
        look(32'h0000_0100, "R6");

        // R2: saturate low, then climb back
        train(32'h0000_0100, 1'b0, 32'h0, 1'b0, "R2");
        train(32'h0000_0100, 1'b0, 32'h0, 1'b0, "R2");
        train(32'h0000_0100, 1'b1, 32'h0000_0400, 1'b0, "R3");
        look(32'h0000_0100, "R3");
        train(32'h0000_0100, 1'b1, 32'h0000_0400, 1'b0, "R3");
        look(32'h0000_0100, "R3");

        // R4: 0x200 shares counter index with 0x100; 0x104 does not
        look(32'h0000_0200, "R4");
        look(32'h0000_0104, "R4");
        // R7: same buffer index, other tag: miss, then replacement
        train(32'h0000_0200, 1'b1, 32'h0000_0800, 1'b0, "R7");
        look(32'h0000_0200, "R7");
        look(32'h0000_0100, "R7");
        train(32'h0000_0200, 1'b1, 32'h0000_0900, 1'b0, "R5");
        look(32'h0000_0200, "R5");

        // R4: independent counter index climbs on its own
        train(32'h0000_0104, 1'b1, 32'h0000_0A00, 1'b0, "R4");
        look(32'h0000_0104, "R4");
        look(32'h0000_0204, "R4");

        // R10: mispredict flag on/off gives the same training
        train(32'h0000_0108, 1'b1, 32'h0000_0C00, 1'b1, "R10");
        train(32'h0000_010C, 1'b1, 32'h0000_0C00, 1'b0, "R10");
        look(32'h0000_0108, "R10");
        look(32'h0000_010C, "R10");

        // R2 and R5: pseudo-random sweep over a small address window
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] fpc, upc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            upc = {19'h0, lfsr[4], 4'h0, lfsr[5:0], 2'b00};
            fpc = {19'h0, lfsr[12], 4'h0, lfsr[11:6], 2'b00};
            if (lfsr[3]) fpc = upc;
            step(fpc, lfsr[13], upc, lfsr[14], {14'h0, lfsr, 2'b00}, lfsr[15], "R2");
        end

        @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule